// File: doc/BRIEF.md
# Fixed-Point Coupled Update Iterator

This block runs a fixed-point numerical integration loop over three coupled state variables. It takes one set of five operands (x, y, u, dx and a), then repeats an update step. Each step advances x by dx, updates u and y from the state held before the step, and tests whether the old x lies below the bound a. After the step whose test is true, it returns the final y. All values are 16-bit two's-complement numbers with 8 fractional bits.

Each iteration runs on a fixed four-cycle schedule. The work is shared across four multiplier instances and two ALU instances, and each ALU performs at most one operation per cycle. A parameter `MAX_ITER` caps the number of iterations, so a loop that never meets its exit test still ends and reports a timeout.

Operands arrive on a valid/ready input and the result leaves on a valid/ready output. Input rules: the input is ready only while the block is idle. An operand set is taken on a clock edge where both `in_valid` and `in_ready` are high. Output rules: once `res_valid` rises, `y_out` and `timeout` hold their values for as long as `res_ready` stays low. On the edge where `res_valid` and `res_ready` are both high, the block returns to idle.

Top module: `diffeq_stepper`

## Requirements
- R1: `in_ready` is high only while idle. Operands are captured on an edge with `in_valid` and `in_ready` both high. `in_valid` pulses seen while the block is busy or holding a result are ignored and do not change the result.
- R2: Each iteration computes x_next = x + dx, wrapping modulo 2^16.
- R3: A product is fmul(p,q) = bits [23:8] of the full 32-bit signed product. Each iteration computes t1=fmul(0x0300,x), t2=fmul(u,dx), t3=fmul(0x0300,y), t4=fmul(t1,t2), t5=fmul(t3,dx) and u_next = (u - t4) - t5, using only values from before the iteration.
- R4: Each iteration computes y_next = y + t2, with t2 taken from the u held before the iteration.
- R5: The exit test is the signed comparison x < a on the x held before the iteration. x, u and y are committed together. At least one iteration always runs, and the loop ends after the first iteration whose test is true. `y_out` then shows the committed y.
- R6: Every iteration takes exactly 4 cycles. After N iterations, `res_valid` rises 4·N clock edges after the accepting edge. `busy` is high for exactly those cycles.
- R7: While `res_valid` is high and `res_ready` is low, `res_valid`, `y_out` and `timeout` stay unchanged. On the edge with `res_valid` and `res_ready` both high, the block goes idle and `in_ready` is high in the next cycle.
- R8: If `MAX_ITER` iterations finish without a true exit test, the loop stops. The result is then presented with `timeout` = 1. `timeout` is 0 on a normal exit and whenever `res_valid` is low.
- R9: A synchronous active-high `rst` makes the block idle: `in_ready`=1, `busy`=0, `res_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Block idle and able to take operands |
| x_in | input | 16 | Initial x |
| y_in | input | 16 | Initial y |
| u_in | input | 16 | Initial u |
| dx_in | input | 16 | Step size |
| a_in | input | 16 | Exit bound |
| busy | output | 1 | Iterations in progress |
| res_valid | output | 1 | Result presented |
| res_ready | input | 1 | Consumer takes the result |
| y_out | output | 16 | Final y |
| timeout | output | 1 | Result ended by the iteration cap |

## Verification
Some properties are checked on every cycle: `busy`, `in_ready` and `res_valid` are mutually exclusive, an accepted operand set moves the block to busy, a result held under back-pressure stays stable, a result taken by the consumer returns the block to idle, and the total busy time is a multiple of four cycles that never exceeds the cap. Other behaviours can only be shown by the bench scenarios, by comparing against a behavioural loop: the arithmetic of the coupled update, including truncation and wrap, the signed exit test on the old x, the exact iteration count, and the timeout path.

// File: rtl/diffeq_pkg.sv
package diffeq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_S1, ST_S2, ST_S3, ST_S4, ST_HOLD
  } step_t;

  typedef enum logic [1:0] {
    ALU_ADD, ALU_SUB, ALU_LT, ALU_NOP
  } alu_op_t;
endpackage

// File: rtl/fx_mul.sv
module fx_mul #(
  parameter int W    = 16,
  parameter int FRAC = 8
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic [W-1:0] prod
);
  localparam int PW = 2 * W;
  logic [PW-1:0] full;

  always_comb begin
    full = {{W{op_a[W-1]}}, op_a} * {{W{op_b[W-1]}}, op_b};
    prod = full[FRAC +: W];
  end
endmodule

// File: rtl/fx_alu.sv
module fx_alu
  import diffeq_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_t      op,
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  output logic [W-1:0] res
);
  always_comb begin
    unique case (op)
      ALU_ADD: res = lhs + rhs;
      ALU_SUB: res = lhs - rhs;
      ALU_LT:  res = {{(W-1){1'b0}}, ($signed(lhs) < $signed(rhs))};
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/diffeq_ctrl.sv
module diffeq_ctrl
  import diffeq_pkg::*;
#(
  parameter int MAX_ITER = 1024
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  in_valid,
  input  logic  res_ready,
  input  logic  exit_flag,
  output step_t step,
  output logic  accept,
  output logic  finish,
  output logic  capped
);
  localparam int IW = $clog2(MAX_ITER + 1);
  localparam logic [IW-1:0] LAST = IW'(MAX_ITER - 1);

  logic [IW-1:0] iter_q;

  assign accept = (step == ST_IDLE) && in_valid;
  assign finish = (step == ST_S4) && (exit_flag || iter_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      step   <= ST_IDLE;
      iter_q <= '0;
      capped <= 1'b0;
    end else begin
      unique case (step)
        ST_IDLE: if (accept) begin
          step   <= ST_S1;
          iter_q <= '0;
          capped <= 1'b0;
        end
        ST_S1: step <= ST_S2;
        ST_S2: step <= ST_S3;
        ST_S3: step <= ST_S4;
        ST_S4: begin
          if (finish) begin
            step   <= ST_HOLD;
            capped <= !exit_flag;
          end else begin
            step   <= ST_S1;
            iter_q <= iter_q + 1'b1;
          end
        end
        ST_HOLD: if (res_ready) begin
          step   <= ST_IDLE;
          capped <= 1'b0;
        end
        default: step <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/diffeq_stepper.sv
module diffeq_stepper
  import diffeq_pkg::*;
#(
  parameter int W        = 16,
  parameter int FRAC     = 8,
  parameter int MAX_ITER = 1024
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] y_in,
  input  logic [W-1:0] u_in,
  input  logic [W-1:0] dx_in,
  input  logic [W-1:0] a_in,
  output logic         busy,
  output logic         res_valid,
  input  logic         res_ready,
  output logic [W-1:0] y_out,
  output logic         timeout
);
  localparam int NMUL = 4;
  localparam int NALU = 2;
  localparam logic [W-1:0] K3 = W'(3) << FRAC;

  step_t step;
  logic  accept, finish, capped;

  logic [W-1:0] x_q, y_q, u_q, dx_q, a_q;
  logic [W-1:0] xn_q, yn_q, t1_q, t2_q, t3_q, t4_q, t5_q, t6_q;
  logic         c_q;

  logic [W-1:0] mul_a [NMUL];
  logic [W-1:0] mul_b [NMUL];
  logic [W-1:0] mul_p [NMUL];
  alu_op_t      alu_op [NALU];
  logic [W-1:0] alu_l [NALU];
  logic [W-1:0] alu_r [NALU];
  logic [W-1:0] alu_y [NALU];

  diffeq_ctrl #(.MAX_ITER(MAX_ITER)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .res_ready(res_ready),
    .exit_flag(c_q),
    .step     (step),
    .accept   (accept),
    .finish   (finish),
    .capped   (capped)
  );

  for (genvar gm = 0; gm < NMUL; gm++) begin : g_mul
    fx_mul #(.W(W), .FRAC(FRAC)) u_mul (
      .op_a(mul_a[gm]),
      .op_b(mul_b[gm]),
      .prod(mul_p[gm])
    );
  end

  for (genvar ga = 0; ga < NALU; ga++) begin : g_alu
    fx_alu #(.W(W)) u_alu (
      .op (alu_op[ga]),
      .lhs(alu_l[ga]),
      .rhs(alu_r[ga]),
      .res(alu_y[ga])
    );
  end

  // Operand steering per control step; each ALU carries one operation per step.
  always_comb begin
    for (int i = 0; i < NMUL; i++) begin
      mul_a[i] = '0;
      mul_b[i] = '0;
    end
    for (int j = 0; j < NALU; j++) begin
      alu_op[j] = ALU_NOP;
      alu_l[j]  = '0;
      alu_r[j]  = '0;
    end
    unique case (step)
      ST_S1: begin
        mul_a[0] = K3;  mul_b[0] = x_q;
        mul_a[1] = u_q; mul_b[1] = dx_q;
        mul_a[2] = K3;  mul_b[2] = y_q;
        alu_op[0] = ALU_ADD; alu_l[0] = x_q; alu_r[0] = dx_q;
        alu_op[1] = ALU_LT;  alu_l[1] = x_q; alu_r[1] = a_q;
      end
      ST_S2: begin
        mul_a[0] = t1_q; mul_b[0] = t2_q;
        mul_a[3] = t3_q; mul_b[3] = dx_q;
        alu_op[0] = ALU_ADD; alu_l[0] = y_q; alu_r[0] = t2_q;
      end
      ST_S3: begin
        alu_op[0] = ALU_SUB; alu_l[0] = u_q; alu_r[0] = t4_q;
      end
      ST_S4: begin
        alu_op[1] = ALU_SUB; alu_l[1] = t6_q; alu_r[1] = t5_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q <= '0; y_q <= '0; u_q <= '0; dx_q <= '0; a_q <= '0;
      xn_q <= '0; yn_q <= '0; c_q <= 1'b0;
      t1_q <= '0; t2_q <= '0; t3_q <= '0;
      t4_q <= '0; t5_q <= '0; t6_q <= '0;
    end else begin
      if (accept) begin
        x_q  <= x_in;
        y_q  <= y_in;
        u_q  <= u_in;
        dx_q <= dx_in;
        a_q  <= a_in;
      end
      unique case (step)
        ST_S1: begin
          t1_q <= mul_p[0];
          t2_q <= mul_p[1];
          t3_q <= mul_p[2];
          xn_q <= alu_y[0];
          c_q  <= alu_y[1][0];
        end
        ST_S2: begin
          t4_q <= mul_p[0];
          t5_q <= mul_p[3];
          yn_q <= alu_y[0];
        end
        ST_S3: t6_q <= alu_y[0];
        ST_S4: begin
          x_q <= xn_q;
          y_q <= yn_q;
          u_q <= alu_y[1];
        end
        default: ;
      endcase
    end
  end

  assign in_ready  = (step == ST_IDLE);
  assign busy      = (step == ST_S1) || (step == ST_S2) ||
                     (step == ST_S3) || (step == ST_S4);
  assign res_valid = (step == ST_HOLD);
  assign y_out     = y_q;
  assign timeout   = res_valid && capped;
endmodule

// File: rtl/diffeq_stepper_chk.sv
module diffeq_stepper_chk #(
  parameter int W        = 16,
  parameter int MAX_ITER = 1024
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_ready,
  input logic         busy,
  input logic         res_valid,
  input logic         res_ready,
  input logic [W-1:0] y_out,
  input logic         timeout
);
  logic [31:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst) busy_cnt <= '0;
    else if (in_valid && in_ready) busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1;
  end

  p_accept_busy_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> busy);

  p_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
    busy |-> (!in_ready && !res_valid));

  p_period_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(res_valid) |-> (busy_cnt[1:0] == 2'b00 && busy_cnt != 0 &&
                          busy_cnt <= 32'(4 * MAX_ITER)));

  p_hold_stable_r7: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |=> (res_valid && $stable(y_out) && $stable(timeout)));

  p_release_r7: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_ready) |=> in_ready);

  p_timeout_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> !timeout);
endmodule

bind diffeq_stepper diffeq_stepper_chk #(.W(W), .MAX_ITER(MAX_ITER)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .busy     (busy),
  .res_valid(res_valid),
  .res_ready(res_ready),
  .y_out    (y_out),
  .timeout  (timeout)
);

// File: tb/tb_diffeq_stepper.sv
module tb_diffeq_stepper;
  localparam int CAP = 24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        res_ready = 1'b0;
  logic [15:0] x_in = '0, y_in = '0, u_in = '0, dx_in = '0, a_in = '0;
  logic        in_ready, busy, res_valid, timeout;
  logic [15:0] y_out;

  int checks = 0;
  int fails  = 0;
  longint cyc = 0;

  always #10 clk = ~clk;

  diffeq_stepper #(.W(16), .FRAC(8), .MAX_ITER(CAP)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .x_in(x_in), .y_in(y_in), .u_in(u_in), .dx_in(dx_in), .a_in(a_in),
    .busy(busy), .res_valid(res_valid), .res_ready(res_ready),
    .y_out(y_out), .timeout(timeout)
  );

  function automatic logic [15:0] fmul(input logic [15:0] p, input logic [15:0] q);
    int full;
    full = int'($signed(p)) * int'($signed(q));
    return full[23:8];
  endfunction

  task automatic ref_loop(input logic [15:0] x0, y0, u0, dx0, a0,
                          output logic [15:0] yf, output int n, output bit to);
    logic [15:0] x, y, u, t1, t2, t3, t4, t5;
    bit c;
    x = x0; y = y0; u = u0; n = 0; to = 0;
    forever begin
      c  = ($signed(x) < $signed(a0));
      t1 = fmul(16'h0300, x);
      t2 = fmul(u, dx0);
      t3 = fmul(16'h0300, y);
      t4 = fmul(t1, t2);
      t5 = fmul(t3, dx0);
      x  = x + dx0;
      y  = y + t2;
      u  = (u - t4) - t5;
      n++;
      if (c) break;
      if (n == CAP) begin to = 1; break; end
    end
    yf = y;
  endtask

  // Behavioural model: 0 idle, 1 busy, 2 holding a result
  int          m_st = 0;
  int          m_rem = 0;
  logic [15:0] m_y = '0;
  bit          m_to = 0;

  always @(posedge clk) begin
    cyc++;
    if (rst) m_st = 0;
    else case (m_st)
      0: if (in_valid) begin
        int n;
        ref_loop(x_in, y_in, u_in, dx_in, a_in, m_y, n, m_to);
        m_rem = 4 * n;
        m_st  = 1;
      end
      1: begin
        m_rem--;
        if (m_rem == 0) m_st = 2;
      end
      default: if (res_ready) m_st = 0;
    endcase
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    chk("R1 R9 in_ready", in_ready, m_st == 0);
    chk("R6 R9 busy", busy, m_st == 1);
    chk("R7 R9 res_valid", res_valid, m_st == 2);
    chk("R8 timeout", timeout, (m_st == 2) && m_to);
    if (m_st == 2) chk("R2 R3 R4 R5 y_out", y_out, m_y);
  end

  always @(posedge clk) begin
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic run_case(input logic [15:0] x0, y0, u0, dx0, a0, input int hold);
    @(negedge clk);
    x_in = x0; y_in = y0; u_in = u0; dx_in = dx0; a_in = a0;
    in_valid = 1'b1;
    @(negedge clk);
    // R1: junk offered while busy must be ignored
    x_in = 16'h7fff; y_in = 16'h1234; u_in = 16'h4321; dx_in = 16'h0100; a_in = 16'h8000;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    while (!res_valid) @(negedge clk);
    // R7: back-pressure
    repeat (hold) @(negedge clk);
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R5: single iteration, x already below bound
    run_case(16'h0000, 16'h0100, 16'h0080, 16'h0020, 16'h0100, 0);
    // R2 R5: negative step walks x below zero
    run_case(16'h0400, 16'h0200, 16'hff80, 16'hffc0, 16'h0000, 2);
    // R3 R4: larger coupling terms, wrap
    run_case(16'h0300, 16'h7000, 16'h6000, 16'hff00, 16'h0100, 1);
    // R5 signed compare: a negative, x positive
    run_case(16'h0080, 16'h0010, 16'h0010, 16'hff00, 16'hfe00, 0);
    // R8: never exits, hits cap
    run_case(16'h0100, 16'h0040, 16'h0020, 16'h0010, 16'h0000, 3);
    for (int k = 0; k < 12; k++) begin
      logic [15:0] rx, rdx;
      rx  = 16'($urandom_range(0, 1024));
      rdx = 16'(-$signed(16'($urandom_range(16, 200))));
      run_case(rx, 16'($urandom), 16'($urandom), rdx, 16'($urandom_range(0, 256)), k % 3);
    end
    // R9: reset mid-run
    @(negedge clk);
    x_in = 16'h0400; dx_in = 16'hfff0; a_in = 16'h0000; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    run_case(16'h0010, 16'h0100, 16'h0100, 16'hfff0, 16'h0000, 0);
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule